// File: doc/BRIEF.md
# AUX Channel Transfer Sequencer

This block turns one read or write request of any length on a DisplayPort AUX channel into a series of short bursts. Each burst is run through a lower-level AUX transaction engine. The requester supplies a 20-bit target address, a byte count, a direction flag and a flag that picks either a native transaction or an I2C-over-AUX transaction. The sequencer cuts the request into bursts of at most sixteen bytes and keeps a 16-entry burst buffer that it shares with the engine. For each burst it clears that buffer, fills it on writes, issues the command and waits for the engine. On reads it empties the buffer into the requester's memory through a byte pointer.

Each attempt has two timed phases, measured in clock cycles scaled by a cycles-per-millisecond parameter. In the first phase the engine must report that its start bit has self-cleared. In the second phase a reply must arrive. A late phase, a reported AUX error or a nonzero reply status fails the attempt, and the burst is retried from a fresh buffer. Once the retry budget for a burst is used up, the whole request ends with an error.

Top module: `aux_xfer_seq`

## Requirements
- R1: A start with a byte count of zero raises `done` in the cycle after the start is sampled, keeps `err` low and issues nothing to the engine.
- R2: Bursts are min(remaining, 16) bytes long, and each burst's length minus one is carried in command bits 7:4.
- R3: The burst address is presented as three fields: `eng_addr_lo` = bits 7:0, `eng_addr_mid` = bits 15:8 and `eng_addr_hi` = bits 19:16. After each successful burst the address advances by that burst's length.
- R4: Command bit 3 is 1 for a native transaction and 0 for I2C-over-AUX. Bit 0 is 1 for a read and 0 for a write. Bits 2:1 are zero.
- R5: The burst buffer is cleared before every attempt. On writes the burst's bytes sit in entries 0..len-1 before the command is issued, and the entries above len read as zero.
- R6: The data pointer `dptr` starts at 0 for each request and advances by the burst length. A read burst copies buffer entry k to pointer base + k. A write burst loads entry k from pointer base + k.
- R7: If `eng_complete` does not arrive within 20 ms of clock cycles after issue, the attempt fails. For a read, the next issue then follows the previous one by 20·CYC_PER_MS + 2 cycles.
- R8: If `eng_reply` does not arrive within 10 ms of clock cycles after completion, the attempt fails. `eng_reply_clr` pulses only in a cycle where `eng_reply` is high.
- R9: A reply that carries `eng_aux_err` or a nonzero `eng_status` fails the attempt.
- R10: A failed burst is retried up to 10 attempts in total. A later success lets the request continue. A tenth failure ends the request with `done` and `err` set together, and nothing more is issued.
- R11: A start request that arrives while `busy` is high has no effect.
- R12: `busy` rises in the cycle after an accepted start, and `done` is a one-cycle pulse during which `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a request (one-cycle pulse) |
| req_addr | input | 20 | Target address of the first byte |
| req_len | input | LEN_W | Byte count of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_native | input | 1 | 1 = native transaction, 0 = I2C-over-AUX |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Request aborted after the retry budget ran out (with done) |
| dptr | output | LEN_W | Byte pointer into the requester's memory |
| src_byte | input | 8 | Requester byte at dptr, for writes |
| dst_we | output | 1 | Store dst_byte at dptr |
| dst_byte | output | 8 | Byte read from the sink |
| eng_issue | output | 1 | Start one engine transaction |
| eng_addr_lo | output | 8 | Address bits 7:0 |
| eng_addr_mid | output | 8 | Address bits 15:8 |
| eng_addr_hi | output | 4 | Address bits 19:16 |
| eng_cmd | output | 8 | Command: length-1, type, direction |
| eng_complete | input | 1 | Engine start bit has self-cleared (pulse) |
| eng_reply | input | 1 | Reply-received flag |
| eng_aux_err | input | 1 | AUX error flag |
| eng_status | input | 4 | Reply status, nonzero is a failure |
| eng_reply_clr | output | 1 | Clear the reply flags |
| eng_buf_idx | input | 4 | Engine index into the burst buffer |
| eng_buf_we | input | 1 | Engine write to the burst buffer |
| eng_buf_wdata | input | 8 | Engine write data |
| eng_buf_rdata | output | 8 | Burst buffer entry at eng_buf_idx |

## Verification
A zero-length `done` is due one cycle after the edge that samples the start, so the bench checks it at the very next falling edge. On every other request the bench waits for `done`, sampling at falling edges, and takes `busy` and `err` in that same cycle. The timeout checks use issue times recorded by the engine model at rising edges. An enable timeout on a read puts exactly 20·CYC_PER_MS + 2 cycles between issues. A reply timeout puts exactly 18 + 10·CYC_PER_MS + 2 cycles between issues, given the model's fixed 18-cycle completion. The bench compares those intervals for equality. "Nothing happens" checks wait out a fixed quiet window before counting issues and `done` pulses.

// File: rtl/aux_xfer_pkg.sv
package aux_xfer_pkg;

    localparam int ADDR_W         = 20;
    localparam int CMD_W          = 8;
    localparam int CMD_NATIVE_BIT = 3;
    localparam int CMD_READ_BIT   = 0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLEAR,
        SQ_LOAD,
        SQ_ISSUE,
        SQ_WAIT_EN,
        SQ_WAIT_RP,
        SQ_COPY
    } seq_state_t;

    typedef struct packed {
        logic [3:0] hi;
        logic [7:0] mid;
        logic [7:0] lo;
    } aux_addr_t;

    typedef struct packed {
        logic pass;
        logic fail;
    } attempt_res_t;

    function automatic aux_addr_t split_addr(input logic [ADDR_W-1:0] a);
        aux_addr_t r;
        r.lo  = a[7:0];
        r.mid = a[15:8];
        r.hi  = a[19:16];
        return r;
    endfunction

    function automatic logic [CMD_W-1:0] make_cmd(input logic [3:0] len_m1,
                                                  input logic native,
                                                  input logic rd);
        logic [CMD_W-1:0] c;
        c = '0;
        c[7:4]            = len_m1;
        c[CMD_NATIVE_BIT] = native;
        c[CMD_READ_BIT]   = rd;
        return c;
    endfunction

endpackage

// File: rtl/aux_burst_track.sv
module aux_burst_track
    import aux_xfer_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int BURST_MAX = 16,
    parameter int CW        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  ptr,
    output logic [CW-1:0]     chunk,
    output logic              last
);
    localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST_MAX);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  rem_q;

    always_comb begin
        chunk = (rem_q > BURST_L) ? CW'(BURST_MAX) : rem_q[CW-1:0];
        last  = (rem_q <= BURST_L);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ptr_q  <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            ptr_q  <= '0;
            rem_q  <= len_in;
        end else if (adv) begin
            addr_q <= addr_q + ADDR_W'(chunk);
            ptr_q  <= ptr_q + LEN_W'(chunk);
            rem_q  <= rem_q - LEN_W'(chunk);
        end
    end

    assign addr = addr_q;
    assign ptr  = ptr_q;

endmodule

// File: rtl/aux_phase_timer.sv
module aux_phase_timer #(
    parameter int EN_CYC = 1000,
    parameter int RP_CYC = 500,
    parameter int TW     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic sel_rp,
    output logic expired
);
    localparam logic [TW-1:0] EN_LAST = TW'(EN_CYC - 1);
    localparam logic [TW-1:0] RP_LAST = TW'(RP_CYC - 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] limit;

    assign limit   = sel_rp ? RP_LAST : EN_LAST;
    assign expired = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

endmodule

// File: rtl/aux_burst_buf.sv
module aux_burst_buf #(
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] flat [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [7:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ent_q <= '0;
            end else if (a_we && (a_idx == IW'(i))) begin
                ent_q <= a_wdata;
            end else if (b_we && (b_idx == IW'(i))) begin
                ent_q <= b_wdata;
            end
        end
        assign flat[i] = ent_q;
    end

    assign a_rdata = flat[a_idx];
    assign b_rdata = flat[b_idx];

endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
    import aux_xfer_pkg::*;
#(
    parameter int BURST_MAX  = 16,
    parameter int ATTEMPTS   = 10,
    parameter int LEN_W      = 12,
    parameter int CYC_PER_MS = 50000,
    parameter int EN_MS      = 20,
    parameter int RPLY_MS    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_start,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    input  logic             req_native,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [LEN_W-1:0] dptr,
    input  logic [7:0]       src_byte,
    output logic             dst_we,
    output logic [7:0]       dst_byte,
    output logic             eng_issue,
    output logic [7:0]       eng_addr_lo,
    output logic [7:0]       eng_addr_mid,
    output logic [3:0]       eng_addr_hi,
    output logic [7:0]       eng_cmd,
    input  logic             eng_complete,
    input  logic             eng_reply,
    input  logic             eng_aux_err,
    input  logic [3:0]       eng_status,
    output logic             eng_reply_clr,
    input  logic [3:0]       eng_buf_idx,
    input  logic             eng_buf_we,
    input  logic [7:0]       eng_buf_wdata,
    output logic [7:0]       eng_buf_rdata
);
    localparam int BIDX_W = $clog2(BURST_MAX);
    localparam int CW     = $clog2(BURST_MAX + 1);
    localparam int AW     = $clog2(ATTEMPTS + 1);
    localparam int EN_CYC = EN_MS * CYC_PER_MS;
    localparam int RP_CYC = RPLY_MS * CYC_PER_MS;
    localparam int TMAX   = (EN_CYC > RP_CYC) ? EN_CYC : RP_CYC;
    localparam int TW     = $clog2(TMAX + 1);

    seq_state_t        state_q, state_d;
    logic              rd_q, native_q;
    logic [CW-1:0]     idx_q;
    logic [AW-1:0]     try_q;
    logic              done_q, err_q;

    logic              trk_load, trk_adv;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_ptr;
    logic [CW-1:0]     chunk;
    logic              last_burst;

    logic              tmr_clr, tmr_run, tmr_sel, tmr_exp;
    logic [7:0]        sq_rdata;

    attempt_res_t      res;
    logic              last_byte, finish_burst, finish_req, give_up, accept;
    aux_addr_t         fields;

    // ---------------- submodules ----------------
    aux_burst_track #(
        .LEN_W(LEN_W), .BURST_MAX(BURST_MAX), .CW(CW)
    ) i_track (
        .clk(clk), .rst(rst),
        .load(trk_load), .addr_in(req_addr), .len_in(req_len),
        .adv(trk_adv),
        .addr(cur_addr), .ptr(cur_ptr), .chunk(chunk), .last(last_burst)
    );

    aux_phase_timer #(
        .EN_CYC(EN_CYC), .RP_CYC(RP_CYC), .TW(TW)
    ) i_timer (
        .clk(clk), .rst(rst),
        .clr(tmr_clr), .run(tmr_run), .sel_rp(tmr_sel), .expired(tmr_exp)
    );

    aux_burst_buf #(
        .DEPTH(BURST_MAX), .IW(BIDX_W)
    ) i_buf (
        .clk(clk), .rst(rst), .clr(state_q == SQ_CLEAR),
        .a_we(state_q == SQ_LOAD), .a_idx(idx_q[BIDX_W-1:0]),
        .a_wdata(src_byte), .a_rdata(sq_rdata),
        .b_we(eng_buf_we), .b_idx(eng_buf_idx[BIDX_W-1:0]),
        .b_wdata(eng_buf_wdata), .b_rdata(eng_buf_rdata)
    );

    // ---------------- attempt outcome ----------------
    always_comb begin
        accept       = (state_q == SQ_IDLE) && req_start;
        last_byte    = ((idx_q + CW'(1)) == chunk);
        res.pass     = (state_q == SQ_WAIT_RP) && eng_reply &&
                       !eng_aux_err && (eng_status == 4'd0);
        res.fail     = ((state_q == SQ_WAIT_EN) && !eng_complete && tmr_exp) ||
                       ((state_q == SQ_WAIT_RP) &&
                        ((eng_reply && (eng_aux_err || (eng_status != 4'd0))) ||
                         (!eng_reply && tmr_exp)));
        give_up      = res.fail && (try_q == AW'(ATTEMPTS - 1));
        finish_burst = ((state_q == SQ_COPY) && last_byte) || (res.pass && !rd_q);
        finish_req   = finish_burst && last_burst;
        trk_load     = accept && (req_len != '0);
        trk_adv      = finish_burst;
        tmr_clr      = (state_q == SQ_ISSUE) ||
                       ((state_q == SQ_WAIT_EN) && eng_complete);
        tmr_run      = (state_q == SQ_WAIT_EN) || (state_q == SQ_WAIT_RP);
        tmr_sel      = (state_q == SQ_WAIT_RP);
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (trk_load) state_d = SQ_CLEAR;
            SQ_CLEAR:   state_d = rd_q ? SQ_ISSUE : SQ_LOAD;
            SQ_LOAD:    if (last_byte) state_d = SQ_ISSUE;
            SQ_ISSUE:   state_d = SQ_WAIT_EN;
            SQ_WAIT_EN: begin
                if (eng_complete)   state_d = SQ_WAIT_RP;
                else if (res.fail)  state_d = give_up ? SQ_IDLE : SQ_CLEAR;
            end
            SQ_WAIT_RP: begin
                if (res.pass) begin
                    if (rd_q)       state_d = SQ_COPY;
                    else            state_d = last_burst ? SQ_IDLE : SQ_CLEAR;
                end else if (res.fail) begin
                    state_d = give_up ? SQ_IDLE : SQ_CLEAR;
                end
            end
            SQ_COPY:    if (last_byte) state_d = last_burst ? SQ_IDLE : SQ_CLEAR;
            default:    state_d = SQ_IDLE;
        endcase
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            rd_q     <= 1'b0;
            native_q <= 1'b0;
            idx_q    <= '0;
            try_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (accept && (req_len == '0)) || finish_req || give_up;
            err_q   <= give_up;

            if (trk_load) begin
                rd_q     <= ~req_write;
                native_q <= req_native;
                try_q    <= '0;
            end else if (res.pass) begin
                try_q    <= '0;
            end else if (res.fail && !give_up) begin
                try_q    <= try_q + AW'(1);
            end

            if ((state_q == SQ_CLEAR) || res.pass) begin
                idx_q <= '0;
            end else if ((state_q == SQ_LOAD) || (state_q == SQ_COPY)) begin
                idx_q <= last_byte ? '0 : idx_q + CW'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    assign fields        = split_addr(cur_addr);
    assign busy          = (state_q != SQ_IDLE);
    assign done          = done_q;
    assign err           = err_q;
    assign dptr          = cur_ptr + LEN_W'(idx_q);
    assign dst_we        = (state_q == SQ_COPY);
    assign dst_byte      = sq_rdata;
    assign eng_issue     = (state_q == SQ_ISSUE);
    assign eng_addr_lo   = fields.lo;
    assign eng_addr_mid  = fields.mid;
    assign eng_addr_hi   = fields.hi;
    assign eng_cmd       = make_cmd(4'(chunk - CW'(1)), native_q, rd_q);
    assign eng_reply_clr = (state_q == SQ_WAIT_RP) && eng_reply;

endmodule

// File: rtl/aux_xfer_seq_chk.sv
module aux_xfer_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       eng_issue,
    input logic [7:0] eng_cmd,
    input logic       eng_reply,
    input logic       eng_reply_clr
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R12
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_start));

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R8
    reply_clr_chk: assert property (@(posedge clk) disable iff (rst)
        eng_reply_clr |-> eng_reply);

    // R4
    cmd_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        eng_issue |-> (eng_cmd[2:1] == 2'b00));

    // R7
    issue_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_issue |=> !eng_issue);

endmodule

bind aux_xfer_seq aux_xfer_seq_chk i_chk (
    .clk(clk), .rst(rst), .req_start(req_start), .busy(busy), .done(done),
    .err(err), .eng_issue(eng_issue), .eng_cmd(eng_cmd),
    .eng_reply(eng_reply), .eng_reply_clr(eng_reply_clr)
);

// File: tb/test_aux_xfer_seq.sv
module test_aux_xfer_seq;
    localparam int CPM    = 4;
    localparam int EN_CYC = 20 * CPM;
    localparam int RP_CYC = 10 * CPM;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic [19:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_write = 1'b0, req_native = 1'b0;
    logic        busy, done, err, dst_we, eng_issue, eng_reply_clr;
    logic [11:0] dptr;
    logic [7:0]  src_byte, dst_byte, eng_addr_lo, eng_addr_mid, eng_cmd;
    logic [3:0]  eng_addr_hi;
    logic        eng_complete = 1'b0, eng_reply = 1'b0, eng_aux_err = 1'b0;
    logic [3:0]  eng_status = '0;
    logic [3:0]  eng_buf_idx;
    logic        eng_buf_we;
    logic [7:0]  eng_buf_wdata, eng_buf_rdata;

    aux_xfer_seq #(.CYC_PER_MS(CPM)) i_aux_xfer_seq (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_native(req_native),
        .busy(busy), .done(done), .err(err), .dptr(dptr), .src_byte(src_byte),
        .dst_we(dst_we), .dst_byte(dst_byte), .eng_issue(eng_issue),
        .eng_addr_lo(eng_addr_lo), .eng_addr_mid(eng_addr_mid),
        .eng_addr_hi(eng_addr_hi), .eng_cmd(eng_cmd),
        .eng_complete(eng_complete), .eng_reply(eng_reply),
        .eng_aux_err(eng_aux_err), .eng_status(eng_status),
        .eng_reply_clr(eng_reply_clr), .eng_buf_idx(eng_buf_idx),
        .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata),
        .eng_buf_rdata(eng_buf_rdata)
    );

    int total = 0, bad = 0;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // requester memory
    logic [7:0] src_mem [0:255];
    logic [7:0] dst_mem [0:255];
    assign src_byte = src_mem[dptr[7:0]];
    always @(posedge clk) if (dst_we) dst_mem[dptr[7:0]] <= dst_byte;

    // engine model
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          issue_n = 0, done_n = 0;
    logic [19:0] rec_addr [0:63];
    logic [7:0]  rec_cmd [0:63];
    int          rec_t [0:63];
    int          fail_left = 0, fail_kind = 0;
    logic        e_active = 1'b0, e_read = 1'b0;
    int          step = 0, kind = 4, e_len = 0;
    logic [19:0] e_addr = '0;
    logic [7:0]  cap [0:15];
    logic [7:0]  sink_mem [0:255];

    assign eng_buf_idx   = step[3:0];
    assign eng_buf_we    = e_active && (step < 16) && e_read;
    assign eng_buf_wdata = pat(e_addr + 20'(step));

    always @(posedge clk) begin
        if (done) done_n <= done_n + 1;
        eng_complete <= 1'b0;
        if (eng_reply_clr) begin
            eng_reply <= 1'b0; eng_aux_err <= 1'b0; eng_status <= '0;
        end
        if (eng_issue) begin
            if (issue_n < 64) begin
                rec_addr[issue_n] <= {eng_addr_hi, eng_addr_mid, eng_addr_lo};
                rec_cmd[issue_n]  <= eng_cmd;
                rec_t[issue_n]    <= cyc;
            end
            issue_n  <= issue_n + 1;
            e_addr   <= {eng_addr_hi, eng_addr_mid, eng_addr_lo};
            e_read   <= eng_cmd[0];
            e_len    <= int'(eng_cmd[7:4]) + 1;
            e_active <= 1'b1;
            step     <= 0;
            if (fail_left > 0) begin
                kind <= fail_kind; fail_left <= fail_left - 1;
            end else kind <= 4;
        end else if (e_active) begin
            if (step < 16) begin
                if (!e_read) begin
                    cap[step] <= eng_buf_rdata;
                    if (step < e_len) sink_mem[e_addr[7:0] + 8'(step)] <= eng_buf_rdata;
                end
                step <= step + 1;
            end else if (step == 16) begin
                if (kind != 0) eng_complete <= 1'b1;
                step <= 17;
            end else begin
                e_active <= 1'b0;
                if (kind != 0 && kind != 1) begin
                    eng_reply   <= 1'b1;
                    eng_aux_err <= (kind == 2);
                    eng_status  <= (kind == 3) ? 4'h1 : 4'h0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [19:0] a, input int n, input logic wr, input logic nat);
        @(negedge clk);
        req_addr = a; req_len = 12'(n); req_write = wr; req_native = nat; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0 && eng_issue == 0 && err == 0, "R12",
              "reset state", {busy, done, eng_issue, err}, 0);
    endtask

    task automatic t_zero_len();
        int b = issue_n;
        kick(20'h00123, 0, 1'b0, 1'b1);
        check(done == 1 && err == 0 && busy == 0, "R1", "zero-length done",
              {done, err, busy}, 3'b100);
        repeat (20) @(negedge clk);
        check(issue_n == b, "R1", "zero-length issues", issue_n - b, 0);
    endtask

    task automatic t_native_read20();
        int b = issue_n, nbad = 0;
        kick(20'h123F8, 20, 1'b0, 1'b1);
        check(busy == 1, "R12", "busy after start", busy, 1);
        wait_done();
        check(err == 0 && busy == 0, "R12", "read20 done state", {err, busy}, 0);
        check(issue_n - b == 2, "R2", "read20 burst count", issue_n - b, 2);
        check(rec_addr[b] == 20'h123F8, "R3", "burst0 addr", rec_addr[b], 20'h123F8);
        check(rec_addr[b+1] == 20'h12408, "R3", "burst1 addr", rec_addr[b+1], 20'h12408);
        check(rec_cmd[b] == 8'hF9, "R4", "burst0 cmd", rec_cmd[b], 8'hF9);
        check(rec_cmd[b+1] == 8'h39, "R2", "burst1 cmd", rec_cmd[b+1], 8'h39);
        for (int k = 0; k < 20; k++)
            if (dst_mem[k] !== pat(20'h123F8 + 20'(k))) nbad++;
        check(nbad == 0, "R6", "read20 data mismatches", nbad, 0);
    endtask

    task automatic t_i2c_write3();
        int b = issue_n, nbad = 0, nz = 0;
        kick(20'h00050, 3, 1'b1, 1'b0);
        wait_done();
        check(issue_n - b == 1 && err == 0, "R4", "i2c write issue", issue_n - b, 1);
        check(rec_cmd[b] == 8'h20, "R4", "i2c write cmd", rec_cmd[b], 8'h20);
        for (int k = 0; k < 3; k++) if (sink_mem[8'h50 + 8'(k)] !== src_mem[k]) nbad++;
        check(nbad == 0, "R5", "write bytes loaded", nbad, 0);
        for (int k = 3; k < 16; k++) if (cap[k] !== 8'h00) nz++;
        check(nz == 0, "R5", "buffer cleared above length", nz, 0);
    endtask

    task automatic t_write17();
        int b = issue_n, nbad = 0;
        kick(20'h000A0, 17, 1'b1, 1'b1);
        wait_done();
        check(issue_n - b == 2, "R2", "write17 bursts", issue_n - b, 2);
        check(rec_cmd[b] == 8'hF8 && rec_cmd[b+1] == 8'h08, "R2", "write17 cmds",
              {rec_cmd[b], rec_cmd[b+1]}, 16'hF808);
        check(rec_addr[b+1] == 20'h000B0, "R3", "write17 advance", rec_addr[b+1], 20'hB0);
        for (int k = 0; k < 17; k++) if (sink_mem[8'hA0 + 8'(k)] !== src_mem[k]) nbad++;
        check(nbad == 0, "R6", "write17 pointer advance", nbad, 0);
    endtask

    task automatic t_retry_ok();
        int b = issue_n, nbad = 0;
        fail_kind = 2; fail_left = 3;
        kick(20'h00040, 5, 1'b0, 1'b1);
        wait_done();
        check(issue_n - b == 4 && err == 0, "R10", "retry then pass", issue_n - b, 4);
        for (int k = 0; k < 5; k++) if (dst_mem[k] !== pat(20'h40 + 20'(k))) nbad++;
        check(nbad == 0, "R9", "data after aux error retries", nbad, 0);
        b = issue_n;
        fail_kind = 3; fail_left = 1;
        kick(20'h00060, 1, 1'b0, 1'b1);
        wait_done();
        check(issue_n - b == 2 && err == 0, "R9", "nonzero status retried", issue_n - b, 2);
    endtask

    task automatic t_timeouts();
        int b = issue_n;
        fail_kind = 0; fail_left = 1;
        kick(20'h00010, 1, 1'b0, 1'b1);
        wait_done();
        check(issue_n - b == 2 && err == 0, "R7", "enable timeout retried", issue_n - b, 2);
        check(rec_t[b+1] - rec_t[b] == EN_CYC + 2, "R7", "enable timeout interval",
              rec_t[b+1] - rec_t[b], EN_CYC + 2);
        b = issue_n;
        fail_kind = 1; fail_left = 1;
        kick(20'h00020, 1, 1'b0, 1'b1);
        wait_done();
        check(issue_n - b == 2 && err == 0, "R8", "reply timeout retried", issue_n - b, 2);
        check(rec_t[b+1] - rec_t[b] == 18 + RP_CYC + 2, "R8", "reply timeout interval",
              rec_t[b+1] - rec_t[b], 18 + RP_CYC + 2);
    endtask

    task automatic t_exhaust();
        int b = issue_n;
        fail_kind = 2; fail_left = 10;
        kick(20'h00070, 1, 1'b0, 1'b1);
        wait_done();
        check(err == 1 && busy == 0, "R10", "abort flags", {err, busy}, 2'b10);
        repeat (100) @(negedge clk);
        check(issue_n - b == 10, "R10", "attempts before abort", issue_n - b, 10);
    endtask

    task automatic t_ignore_busy();
        int b = issue_n, d = done_n;
        kick(20'h00300, 4, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        req_addr = 20'h00777; req_len = 12'd8; req_write = 1'b1; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done();
        repeat (60) @(negedge clk);
        check(issue_n - b == 1 && rec_addr[b] == 20'h00300, "R11", "start while busy ignored",
              issue_n - b, 1);
        check(done_n - d == 1, "R11", "single done", done_n - d, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            src_mem[i] = 8'(i * 7 + 3);
            dst_mem[i] = '0;
            sink_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_native_read20();
        t_i2c_write3();
        t_write17();
        t_retry_ok();
        t_timeouts();
        t_exhaust();
        t_ignore_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule